// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the external memory cycles of a 16-bit controller whose off-chip bus puts the low address byte and the data byte on the same eight wires. The core hands it one request at a time: a program fetch, a data read or a data write, with a 16-bit address and, for writes, a data byte. The block then drives the low byte bus, the separate high address byte, an address latch strobe, and exactly one of three active-low strobes: program fetch, data read or data write. One clock period of the block equals one oscillator period. All phase lengths are counted in these periods.

A request is offered on a valid/ready pair. `req_ready` is high only while no cycle is in flight. A request is taken on the edge where `req_valid` and `req_ready` are both high. While the bus is busy, the core must hold the request steady and wait. Each accepted request ends with exactly one `rsp_valid` pulse, which has no back-pressure. For reads and fetches the pulse carries the byte read. A slow data device can hold off the end of a read or write by raising `wait_in`. Program fetches are never stretched. When the external-access pin `ea_n` is high, fetches below the internal program boundary complete at once without touching the bus.

Top module: `xmem_mux_bus`

## Requirements
- R1: While `rst_n` is low, and in the first period after it rises: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0, `rsp_valid`=0 and `req_ready`=1. Reset is asynchronous, so a reset in the middle of a cycle quiets all strobes immediately.
- R2: Every external cycle starts with `ale` high for exactly 3 consecutive periods, beginning in the period after acceptance.
- R3: The low address byte is on `ad_out` with `ad_oe`=1 during the last 2 `ale` periods and during the 1 period after `ale` falls. The bus is released in the first `ale` period. `a_hi` carries address bits 15:8 from the first `ale` period until the response.
- R4: The strobe goes low exactly 1 period after `ale` falls. With no stretch it stays low for exactly 4 periods.
- R5: `req_kind` encodings: 0 = fetch, driving `psen_n`. 1 or 3 = read, driving `rd_n`. 2 = write, driving `wr_n`. Only the selected strobe ever goes low, and never two at once.
- R6: On a read or write, `wait_in` is sampled at the end of the 4th strobe period and at the end of every period added after it. Each high sample adds one period of strobe. On a fetch, `wait_in` has no effect.
- R7: On a write, the data byte is on `ad_out` with `ad_oe`=1 from the first strobe period through the one period after `wr_n` rises.
- R8: `ad_in` is captured on the edge where `rd_n` or `psen_n` rises. `rsp_valid` is high for exactly the one following period, with `rsp_data` = that byte and `rsp_ext`=1. Writes also get one `rsp_valid` in that period.
- R9: With `ea_n`=1, a fetch whose address is below 0xC000 makes no bus activity. Its `rsp_valid` comes in the period after acceptance, with `rsp_ext`=0 and `rsp_data`=0. With `ea_n`=0, every fetch is external. Reads and writes are always external.
- R10: `req_ready` is low from the period after acceptance until the response period, inclusive, and high again in the period after. A request held valid while busy is taken only then.
- R11: `ad_oe` is low in every period that does not drive the address or write data. This includes all read and fetch strobe periods and the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 fetch, 1/3 read, 2 write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-period completion pulse |
| rsp_data | output | 8 | Byte read (0 for writes and internal fetches) |
| rsp_ext | output | 1 | Completion came from an external cycle |
| ea_n | input | 1 | Low forces all fetches external |
| wait_in | input | 1 | Stretch request for data accesses |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / write data |
| ad_oe | output | 1 | Output enable for the multiplexed byte |
| ad_in | input | 8 | Multiplexed bus input |
| a_hi | output | 8 | High address byte |

## Verification
The hardest situation to reach is a stretch that lands exactly on the right edges. `wait_in` only matters at the end of the fourth strobe period and after. It must be dropped on a precise edge to give a chosen number of added periods. A wait held over a whole fetch must also leave that fetch unchanged. The bench counts the strobe periods it has seen at each falling clock edge. It keeps `wait_in` high until the count reaches four plus the wanted stretch. The vectors cover stretches of zero to three on reads and writes, and a permanently high wait on fetches.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_READX = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INT,
    PH_ALE,
    PH_HOLD,
    PH_STRB,
    PH_TAIL
  } phase_e;
endpackage

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
#(
  parameter int ALE_PERIODS  = 3,
  parameter int STRB_PERIODS = 4,
  parameter int CW           = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ext,
  input  logic          start_int,
  input  logic          stretchable,
  input  logic          wait_in,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          strobe_last
);
  localparam logic [CW-1:0] ALE_END  = CW'(ALE_PERIODS - 1);
  localparam logic [CW-1:0] STRB_END = CW'(STRB_PERIODS - 1);

  phase_e        ph_nx;
  logic [CW-1:0] cnt_nx;
  logic          hold_strb;

  assign hold_strb   = stretchable && wait_in;
  assign strobe_last = (phase == PH_STRB) && (cnt == STRB_END) && !hold_strb;

  always_comb begin
    ph_nx  = phase;
    cnt_nx = cnt;
    unique case (phase)
      PH_IDLE: begin
        cnt_nx = '0;
        if (start_ext)      ph_nx = PH_ALE;
        else if (start_int) ph_nx = PH_INT;
      end
      PH_INT:  ph_nx = PH_IDLE;
      PH_ALE: begin
        if (cnt == ALE_END) begin
          ph_nx  = PH_HOLD;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      PH_HOLD: begin
        ph_nx  = PH_STRB;
        cnt_nx = '0;
      end
      PH_STRB: begin
        if (cnt == STRB_END) begin
          if (!hold_strb) begin
            ph_nx  = PH_TAIL;
            cnt_nx = '0;
          end
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      PH_TAIL: ph_nx = PH_IDLE;
      default: begin
        ph_nx  = PH_IDLE;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= ph_nx;
      cnt   <= cnt_nx;
    end
  end
endmodule

// File: rtl/xmb_req_hold.sv
module xmb_req_hold
  import xmb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    kind_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output acc_kind_e     kind,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind  <= ACC_FETCH;
      addr  <= '0;
      wdata <= '0;
    end else if (load) begin
      kind  <= acc_kind_e'(kind_in);
      addr  <= addr_in;
      wdata <= wdata_in;
    end
  end
endmodule

// File: rtl/xmb_pin_map.sv
module xmb_pin_map
  import xmb_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int ALE_PERIODS = 3,
  parameter int ADDR_LEAD   = 2,
  parameter int CW          = 3
) (
  input  phase_e        phase,
  input  logic [CW-1:0] cnt,
  input  acc_kind_e     kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] a_hi
);
  logic lead_win;
  logic addr_drv;
  logic data_drv;
  logic strb_on;

  generate
    if (ADDR_LEAD >= ALE_PERIODS) begin : g_full_lead
      assign lead_win = 1'b1;
    end else begin : g_part_lead
      localparam logic [CW-1:0] LEAD_FROM = CW'(ALE_PERIODS - ADDR_LEAD);
      assign lead_win = (cnt >= LEAD_FROM);
    end
  endgenerate

  assign ale      = (phase == PH_ALE);
  assign strb_on  = (phase == PH_STRB);
  assign addr_drv = (ale && lead_win) || (phase == PH_HOLD);
  assign data_drv = (kind == ACC_WRITE) && (strb_on || phase == PH_TAIL);

  assign psen_n = !(strb_on && kind == ACC_FETCH);
  assign wr_n   = !(strb_on && kind == ACC_WRITE);
  assign rd_n   = !(strb_on && (kind == ACC_READ || kind == ACC_READX));

  assign ad_oe  = addr_drv || data_drv;
  assign ad_out = addr_drv ? addr[DW-1:0] : (data_drv ? wdata : '0);
  assign a_hi   = addr[AW-1:DW];
endmodule

// File: rtl/xmb_rsp.sv
module xmb_rsp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_done,
  input  logic          is_write,
  input  logic          int_done,
  input  logic [DW-1:0] ad_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_ext
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_ext   <= 1'b0;
    end else begin
      rsp_valid <= ext_done || int_done;
      rsp_ext   <= ext_done;
      rsp_data  <= (ext_done && !is_write) ? ad_in : '0;
    end
  end
endmodule

// File: rtl/xmem_mux_bus.sv
module xmem_mux_bus
  import xmb_pkg::*;
#(
  parameter int          AW           = 16,
  parameter int          DW           = 8,
  parameter int          ALE_PERIODS  = 3,
  parameter int          ADDR_LEAD    = 2,
  parameter int          STRB_PERIODS = 4,
  parameter logic [15:0] INT_ROM_TOP  = 16'hC000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_ext,
  input  logic          ea_n,
  input  logic          wait_in,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] a_hi
);
  localparam int MAXP = (ALE_PERIODS > STRB_PERIODS) ? ALE_PERIODS : STRB_PERIODS;
  localparam int CW   = $clog2(MAXP + 1);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          strobe_last;
  acc_kind_e     kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          accept;
  logic          int_hit;
  logic          start_ext;
  logic          start_int;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign int_hit   = (req_kind == 2'(ACC_FETCH)) && ea_n && (req_addr < AW'(INT_ROM_TOP));
  assign start_ext = accept && !int_hit;
  assign start_int = accept && int_hit;

  xmb_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(start_ext),
    .kind_in(req_kind), .addr_in(req_addr), .wdata_in(req_wdata),
    .kind(kind_q), .addr(addr_q), .wdata(wdata_q)
  );

  xmb_seq #(.ALE_PERIODS(ALE_PERIODS), .STRB_PERIODS(STRB_PERIODS), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_ext(start_ext), .start_int(start_int),
    .stretchable(kind_q != ACC_FETCH), .wait_in(wait_in),
    .phase(phase), .cnt(cnt), .strobe_last(strobe_last)
  );

  xmb_pin_map #(.AW(AW), .DW(DW), .ALE_PERIODS(ALE_PERIODS),
                .ADDR_LEAD(ADDR_LEAD), .CW(CW)) u_pins (
    .phase(phase), .cnt(cnt), .kind(kind_q), .addr(addr_q), .wdata(wdata_q),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi)
  );

  xmb_rsp #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .ext_done(strobe_last),
    .is_write(kind_q == ACC_WRITE), .int_done(start_int), .ad_in(ad_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ext(rsp_ext)
  );
endmodule

// File: rtl/xmb_chk.sv
module xmb_chk #(
  parameter int ALE_PERIODS  = 3,
  parameter int STRB_PERIODS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       ale,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_oe,
  input logic [7:0] a_hi
);
  logic [7:0] ale_run;
  logic [7:0] fetch_run;
  logic       strb_act;

  assign strb_act = !psen_n || !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_run   <= '0;
      fetch_run <= '0;
    end else begin
      ale_run   <= ale ? ale_run + 8'd1 : 8'd0;
      fetch_run <= !psen_n ? fetch_run + 8'd1 : 8'd0;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R5
  AST_ALE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ale_run < 8'(ALE_PERIODS))); // R2
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !strb_act); // R4
  AST_FETCH_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (fetch_run < 8'(STRB_PERIODS))); // R6
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe); // R7
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !ad_oe); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && !strb_act)); // R10
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_act && $past(strb_act)) |-> $stable(a_hi)); // R3
endmodule

bind xmem_mux_bus xmb_chk #(.ALE_PERIODS(ALE_PERIODS), .STRB_PERIODS(STRB_PERIODS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .a_hi(a_hi)
);

// File: tb/sim_xmem_mux_bus.sv
module sim_xmem_mux_bus;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       rsp_ext;
  logic       ea_n = 1'b0;
  logic       wait_in = 1'b0;
  logic       ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0] ad_out, ad_in = '0, a_hi;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = !clk;

  xmem_mux_bus u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ext(rsp_ext),
    .ea_n(ea_n), .wait_in(wait_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic        ea;
    logic [3:0]  w;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h1234, 8'h00, 8'hA5, 1'b0, 4'd0},
    '{2'd1, 16'h0456, 8'h00, 8'h3C, 1'b0, 4'd0},
    '{2'd2, 16'h89AB, 8'h5E, 8'h00, 1'b0, 4'd0},
    '{2'd1, 16'hFF00, 8'h00, 8'hC3, 1'b0, 4'd2},
    '{2'd2, 16'h7001, 8'h81, 8'h00, 1'b0, 4'd3},
    '{2'd0, 16'h2000, 8'h00, 8'h77, 1'b1, 4'd0},
    '{2'd0, 16'hC010, 8'h00, 8'h99, 1'b1, 4'd0},
    '{2'd0, 16'h0040, 8'h00, 8'h6B, 1'b0, 4'd3},
    '{2'd3, 16'h0010, 8'h00, 8'h00, 1'b1, 4'd1},
    '{2'd2, 16'hFFFF, 8'hFF, 8'h00, 1'b0, 4'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit internal = (v.kind == 2'd0) && v.ea && (v.addr < 16'hC000);
    int len = (v.kind == 2'd0) ? 4 : 4 + int'(v.w);
    bit is_wr = (v.kind == 2'd2);
    int strb_seen = 0;
    logic [2:0] exp_pin = (v.kind == 2'd0) ? 3'b011 : (is_wr ? 3'b110 : 3'b101);
    string stag = (v.w != 0) ? "R6" : "R4";
    req_valid = 1'b1; req_kind = v.kind; req_addr = v.addr; req_wdata = v.wd;
    ad_in = v.rd; ea_n = v.ea; wait_in = (v.w != 0);
    if (internal) begin
      @(negedge clk); req_valid = 1'b0;
      chk(rsp_valid && !rsp_ext && rsp_data == 8'h00, "R9 internal response",
          {rsp_valid, rsp_ext, rsp_data}, {1'b1, 1'b0, 8'h00});
      chk(!ale && psen_n && !ad_oe, "R9 no bus activity", {ale, psen_n, ad_oe}, 3'b010);
      @(negedge clk);
      chk(req_ready && !rsp_valid, "R10 ready after internal", {req_ready, rsp_valid}, 2'b10);
    end else begin
      for (int i = 1; i <= len + 6; i++) begin
        bit e_ale  = (i <= 3);
        bit e_addr = (i >= 2 && i <= 4);
        bit e_strb = (i >= 5 && i <= 4 + len);
        bit e_wd   = is_wr && (i >= 5 && i <= 5 + len);
        bit e_rsp  = (i == 5 + len);
        @(negedge clk);
        if (i == 1) req_valid = 1'b0;
        if (i == len + 6) begin
          chk(req_ready, "R10 ready again", req_ready, 1);
        end else begin
          chk(!req_ready, "R10 busy", req_ready, 0);
          chk(ale == e_ale, "R2 ale timing", ale, e_ale);
          chk({psen_n, rd_n, wr_n} == (e_strb ? exp_pin : 3'b111),
              (v.kind == 2'd0 && v.w != 0) ? "R6 fetch ignores wait" : stag,
              {psen_n, rd_n, wr_n}, e_strb ? exp_pin : 3'b111);
          if (e_strb && {psen_n, rd_n, wr_n} != exp_pin && {psen_n, rd_n, wr_n} != 3'b111)
            chk(1'b0, "R5 wrong strobe", {psen_n, rd_n, wr_n}, exp_pin);
          chk(ad_oe == (e_addr || e_wd), "R11 bus enable", ad_oe, e_addr || e_wd);
          if (e_addr) chk(ad_out == v.addr[7:0], "R3 low address", ad_out, v.addr[7:0]);
          if (e_wd)   chk(ad_out == v.wd, "R7 write data", ad_out, v.wd);
          chk(a_hi == v.addr[15:8], "R3 high address", a_hi, v.addr[15:8]);
          chk(rsp_valid == e_rsp, "R8 response pulse", rsp_valid, e_rsp);
          if (e_rsp) begin
            chk(rsp_ext, "R9 external response", rsp_ext, 1);
            if (!is_wr) chk(rsp_data == v.rd, "R8 read byte", rsp_data, v.rd);
          end
        end
        if (!psen_n || !rd_n || !wr_n) strb_seen++;
        wait_in = (v.w != 0) && (strb_seen < 4 + int'(v.w) || v.kind == 2'd0);
      end
    end
    wait_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ale && psen_n && rd_n && wr_n && !ad_oe && !rsp_valid && req_ready,
        "R1 in reset", {ale, psen_n, rd_n, wr_n, ad_oe, rsp_valid, req_ready}, 7'b0111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ale && psen_n && rd_n && wr_n && !ad_oe && !rsp_valid && req_ready,
        "R1 after reset", {ale, psen_n, rd_n, wr_n, ad_oe, rsp_valid, req_ready}, 7'b0111001);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R10: a request held valid while busy is taken only after the response
    begin
      int rises = 0;
      int ready_hi = 0;
      logic prev_ale = 1'b0;
      req_valid = 1'b1; req_kind = 2'd1; req_addr = 16'h0A0B; ea_n = 1'b0;
      for (int i = 1; i <= 11; i++) begin
        @(negedge clk);
        if (ale && !prev_ale) rises++;
        if (req_ready && i <= 9) ready_hi++;
        prev_ale = ale;
      end
      chk(rises == 2 && ready_hi == 0, "R10 held request waits",
          {rises[7:0], ready_hi[7:0]}, 16'h0200);
      req_valid = 1'b0;
      repeat (12) @(negedge clk);
    end

    // R1: reset in the middle of a write strobe
    req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'h3344; req_wdata = 8'h12;
    @(negedge clk); req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(!wr_n, "R4 write strobe active before reset", wr_n, 0);
    rst_n = 1'b0;
    #1;
    chk(wr_n && !ad_oe && !ale && req_ready, "R1 mid-cycle reset",
        {wr_n, ad_oe, ale, req_ready}, 4'b1001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_n && rd_n && psen_n && !rsp_valid, "R1 quiet after release",
        {wr_n, rd_n, psen_n, rsp_valid}, 4'b1110);

    finish_run();
  end
endmodule